// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block works out where instruction fetch goes next in a RISC core whose instructions are all 32 bits wide. In one combinational step it takes the current program counter, the fields the decoder has pulled out of the instruction word, two register operands and a control code. From these it produces the next program counter, a flag that says whether control flow was redirected, and the return address that call-type operations hand to the register file.

There are four kinds of control transfer. A conditional branch can compare the two operands with each other. It can also test the first operand against zero using signed rules. Both kinds add a scaled, sign-extended 16-bit displacement to the address of the following instruction. A direct jump replaces the low 28 bits of that following address with a 26-bit target shifted left by two. A register jump takes its destination from the first operand and raises a flag when that address is not word aligned.

The block has no clock and no handshake. The core places it between decode and the fetch-address register, and every output follows its inputs within the same cycle. Stream back-pressure does not apply here, because the unit holds no data. Fetch, writeback and delay-slot handling belong to the surrounding pipeline.

Top module: `npc_unit`

## Requirements
- R1: With control code 0 (sequential), `next_pc` equals `pc + 4` and `redirect`, `link_en` and `misaligned` are all 0. Whenever `redirect` is 0, `next_pc` equals `pc + 4`.
- R2: Code 1 (branch if operands equal) and code 2 (branch if operands differ) compare `opnd_a` with `opnd_b` across the full word. The branch is taken exactly when the selected relation holds.
- R3: Code 3 (taken when `opnd_a` < 0) and code 4 (taken when `opnd_a` > 0) treat `opnd_a` as a signed two's-complement number. A zero operand takes neither branch.
- R4: Code 5 (taken when `opnd_a` <= 0) and code 6 (taken when `opnd_a` >= 0) are signed. A zero operand takes both.
- R5: A taken branch sets `next_pc` to `pc + 4` plus `disp16` shifted left by two and sign-extended to 32 bits. Negative displacements move backwards.
- R6: Code 7 (direct jump) always redirects. `next_pc` is bits [31:28] of `pc + 4`, then `jump_field`, then two zero bits. The region is taken after the increment, so a jump from the last word of a 256 MiB region lands in the next region.
- R7: Code 8 (register jump) always redirects, and `next_pc` equals `opnd_a` unchanged.
- R8: `misaligned` is 1 exactly when the code is 8 or 12 and `opnd_a[1:0]` is nonzero. For every other code it stays 0, whatever the low operand bits are.
- R9: Codes 9 (less-than-zero branch with link), 10 (greater-or-equal-zero branch with link), 11 (direct jump with link) and 12 (register jump with link) steer the same way as codes 3, 6, 7 and 8. They also set `link_en` to 1 and `link_addr` to `pc + 4`, whether or not the branch is taken.
- R10: Unused codes 13, 14 and 15 behave like code 0.
- R11: Address arithmetic wraps modulo 2^32, so `pc` = 0xFFFFFFFC falls through to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Address of the instruction being resolved |
| ctl_code | input | 4 | Control-transfer kind, encoded as in the requirements |
| disp16 | input | 16 | Branch displacement field, in words |
| jump_field | input | 26 | Direct-jump target field, in words |
| opnd_a | input | 32 | First register operand: compared value or jump address |
| opnd_b | input | 32 | Second register operand for the equality tests |
| next_pc | output | 32 | Address to fetch next |
| redirect | output | 1 | 1 when control leaves the sequential path |
| link_en | output | 1 | 1 when the return address must be written to register 31 |
| link_addr | output | 32 | Return address (`pc + 4`) |
| misaligned | output | 1 | Register-jump destination is not word aligned |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes inputs on the falling clock edge and reads the outputs one nanosecond later. Every vector is therefore checked well before the next rising edge, and no result depends on the order of events at the edge. Displacement signs, zero operands, region crossing and address wrap each get dedicated vectors.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    CT_SEQ      = 4'd0,
    CT_BEQ      = 4'd1,
    CT_BNE      = 4'd2,
    CT_BLTZ     = 4'd3,
    CT_BGTZ     = 4'd4,
    CT_BLEZ     = 4'd5,
    CT_BGEZ     = 4'd6,
    CT_JDIR     = 4'd7,
    CT_JREG     = 4'd8,
    CT_BLTZ_LNK = 4'd9,
    CT_BGEZ_LNK = 4'd10,
    CT_JDIR_LNK = 4'd11,
    CT_JREG_LNK = 4'd12,
    CT_RSV13    = 4'd13,
    CT_RSV14    = 4'd14,
    CT_RSV15    = 4'd15
  } ctl_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_DIR = 2'd2,
    SRC_REG = 2'd3
  } src_e;

  function automatic logic is_cond(input ctl_e c);
    return c inside {CT_BEQ, CT_BNE, CT_BLTZ, CT_BGTZ, CT_BLEZ, CT_BGEZ,
                     CT_BLTZ_LNK, CT_BGEZ_LNK};
  endfunction

  function automatic logic is_link(input ctl_e c);
    return c inside {CT_BLTZ_LNK, CT_BGEZ_LNK, CT_JDIR_LNK, CT_JREG_LNK};
  endfunction

  function automatic logic is_regjump(input ctl_e c);
    return c inside {CT_JREG, CT_JREG_LNK};
  endfunction

  function automatic logic is_dirjump(input ctl_e c);
    return c inside {CT_JDIR, CT_JDIR_LNK};
  endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_e            op,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            holds
);
  logic same, neg, zero, pos;

  always_comb begin
    same = (lhs == rhs);
    neg  = lhs[XLEN-1];
    zero = (lhs == '0);
    pos  = !neg && !zero;
    unique case (op)
      CT_BEQ:                   holds = same;
      CT_BNE:                   holds = !same;
      CT_BLTZ, CT_BLTZ_LNK:     holds = neg;
      CT_BGTZ:                  holds = pos;
      CT_BLEZ:                  holds = neg | zero;
      CT_BGEZ, CT_BGEZ_LNK:     holds = !neg;
      default:                  holds = 1'b0;
    endcase
  end

  // R3/R4: a zero operand satisfies exactly the non-strict tests
  always_comb begin
    if (zero && (op == CT_BLTZ || op == CT_BGTZ))
      a_r3_zero_strict: assert (!holds);
    if (zero && (op == CT_BLEZ || op == CT_BGEZ))
      a_r4_zero_inclusive: assert (holds);
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  disp,
  input  logic [TGT_W-1:0]  jfield,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] reg_tgt
);
  localparam int SEXT_W   = ADDR_W - IMM_W - 2;
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    seq_addr = pc + STEP;
    offset   = {{SEXT_W{disp[IMM_W-1]}}, disp, 2'b00};
    br_addr  = seq_addr + offset;
    dir_addr = {seq_addr[ADDR_W-1 -: REGION_W], jfield, 2'b00};
    reg_tgt  = reg_addr;
  end

  // R5: the branch target differs from the fall-through by the scaled offset
  always_comb begin
    a_r5_offset_dist: assert (br_addr - seq_addr == offset);
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ctl_e              op,
  input  logic              cond_ok,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [ADDR_W-1:0] reg_tgt,
  output logic [ADDR_W-1:0] next_addr,
  output logic              taken,
  output logic              lnk_en,
  output logic [ADDR_W-1:0] lnk_addr,
  output logic              bad_align
);
  src_e src;

  always_comb begin
    if (is_regjump(op))             src = SRC_REG;
    else if (is_dirjump(op))        src = SRC_DIR;
    else if (is_cond(op) && cond_ok) src = SRC_BR;
    else                            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_BR:  next_addr = br_addr;
      SRC_DIR: next_addr = dir_addr;
      SRC_REG: next_addr = reg_tgt;
      default: next_addr = seq_addr;
    endcase
    taken     = (src != SRC_SEQ);
    lnk_en    = is_link(op);
    lnk_addr  = seq_addr;
    bad_align = (src == SRC_REG) && (reg_tgt[1:0] != 2'b00);
  end

  // R8: flag only ever accompanies a register-sourced redirect
  always_comb begin
    if (bad_align)
      a_r8_flag_scope: assert (taken && is_regjump(op));
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [3:0]        ctl_code,
  input  logic [IMM_W-1:0]  disp16,
  input  logic [TGT_W-1:0]  jump_field,
  input  logic [ADDR_W-1:0] opnd_a,
  input  logic [ADDR_W-1:0] opnd_b,
  output logic [ADDR_W-1:0] next_pc,
  output logic              redirect,
  output logic              link_en,
  output logic [ADDR_W-1:0] link_addr,
  output logic              misaligned
);
  localparam int REGION_W = ADDR_W - TGT_W - 2;

  ctl_e              op;
  logic              cond_ok;
  logic [ADDR_W-1:0] seq_addr, br_addr, dir_addr, reg_tgt;

  assign op = ctl_e'(ctl_code);

  npc_cond_eval #(.XLEN(ADDR_W)) u_cond (
    .op    (op),
    .lhs   (opnd_a),
    .rhs   (opnd_b),
    .holds (cond_ok)
  );

  npc_target_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
    .pc       (pc),
    .disp     (disp16),
    .jfield   (jump_field),
    .reg_addr (opnd_a),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .dir_addr (dir_addr),
    .reg_tgt  (reg_tgt)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .op        (op),
    .cond_ok   (cond_ok),
    .seq_addr  (seq_addr),
    .br_addr   (br_addr),
    .dir_addr  (dir_addr),
    .reg_tgt   (reg_tgt),
    .next_addr (next_pc),
    .taken     (redirect),
    .lnk_en    (link_en),
    .lnk_addr  (link_addr),
    .bad_align (misaligned)
  );

  always_comb begin
    // R1: no redirect means fall through to the next word
    if (!redirect)
      a_r1_fallthrough: assert (next_pc == pc + ADDR_W'(4));
    // R9: a link always carries the following instruction's address
    if (link_en)
      a_r9_link_value: assert (link_addr == pc + ADDR_W'(4));
    // R6: direct jumps stay in the region of the following instruction
    if (is_dirjump(op))
      a_r6_region_kept: assert (redirect &&
        next_pc[ADDR_W-1 -: REGION_W] == seq_addr[ADDR_W-1 -: REGION_W]);
    // R7: register jumps go exactly where the operand points
    if (is_regjump(op))
      a_r7_reg_target: assert (redirect && next_pc == opnd_a);
  end
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic [31:0] pc, opnd_a, opnd_b;
  logic [3:0]  ctl_code;
  logic [15:0] disp16;
  logic [25:0] jump_field;
  logic [31:0] next_pc, link_addr;
  logic        redirect, link_en, misaligned;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  npc_unit dut (
    .pc(pc), .ctl_code(ctl_code), .disp16(disp16), .jump_field(jump_field),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .next_pc(next_pc), .redirect(redirect),
    .link_en(link_en), .link_addr(link_addr), .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [31:0] p, input logic [15:0] d,
                       input logic [25:0] j, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ctl_code = c; pc = p; disp16 = d; jump_field = j; opnd_a = a; opnd_b = b;
    #1;
  endtask

  task automatic t_sequential;
    drive(4'd0, 32'h0040_0010, 16'h0003, 26'h0, 32'h5, 32'h5);
    chk("R1 next_pc", next_pc, 32'h0040_0014);
    chk("R1 redirect", {31'b0, redirect}, 32'd0);
    chk("R1 link_en", {31'b0, link_en}, 32'd0);
    chk("R1 misaligned", {31'b0, misaligned}, 32'd0);
  endtask

  task automatic t_equality;
    drive(4'd1, 32'h0040_0010, 16'h0003, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    chk("R2 eq taken", next_pc, 32'h0040_0020);
    drive(4'd1, 32'h0040_0010, 16'h0003, 26'h0, 32'hDEAD_BEEF, 32'h5EAD_BEEF);
    chk("R2 eq not taken", next_pc, 32'h0040_0014);
    drive(4'd2, 32'h0040_0010, 16'h0003, 26'h0, 32'h1, 32'h0);
    chk("R2 ne taken", {31'b0, redirect}, 32'd1);
    drive(4'd2, 32'h0040_0010, 16'h0003, 26'h0, 32'h7, 32'h7);
    chk("R2 ne not taken", {31'b0, redirect}, 32'd0);
  endtask

  task automatic t_zero_cmp;
    // R3 strict tests
    drive(4'd3, 32'h100, 16'h1, 26'h0, 32'h8000_0000, 32'h0);
    chk("R3 ltz neg", {31'b0, redirect}, 32'd1);
    drive(4'd3, 32'h100, 16'h1, 26'h0, 32'h0, 32'h0);
    chk("R3 ltz zero", {31'b0, redirect}, 32'd0);
    drive(4'd4, 32'h100, 16'h1, 26'h0, 32'h7FFF_FFFF, 32'h0);
    chk("R3 gtz pos", {31'b0, redirect}, 32'd1);
    drive(4'd4, 32'h100, 16'h1, 26'h0, 32'h0, 32'h0);
    chk("R3 gtz zero", {31'b0, redirect}, 32'd0);
    drive(4'd4, 32'h100, 16'h1, 26'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R3 gtz neg", {31'b0, redirect}, 32'd0);
    // R4 inclusive tests
    drive(4'd5, 32'h100, 16'h1, 26'h0, 32'h0, 32'h0);
    chk("R4 lez zero", next_pc, 32'h108);
    drive(4'd5, 32'h100, 16'h1, 26'h0, 32'h1, 32'h0);
    chk("R4 lez pos", {31'b0, redirect}, 32'd0);
    drive(4'd6, 32'h100, 16'h1, 26'h0, 32'h0, 32'h0);
    chk("R4 gez zero", {31'b0, redirect}, 32'd1);
    drive(4'd6, 32'h100, 16'h1, 26'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R4 gez neg", {31'b0, redirect}, 32'd0);
  endtask

  task automatic t_br_target;
    drive(4'd1, 32'h0040_0010, 16'hFFFE, 26'h0, 32'h0, 32'h0);
    chk("R5 back by 8", next_pc, 32'h0040_000C);
    drive(4'd1, 32'h0040_0010, 16'h8000, 26'h0, 32'h0, 32'h0);
    chk("R5 max negative", next_pc, 32'h003E_0014);
    drive(4'd1, 32'h0040_0010, 16'h7FFF, 26'h0, 32'h0, 32'h0);
    chk("R5 max positive", next_pc, 32'h0042_0010);
  endtask

  task automatic t_jump_region;
    drive(4'd7, 32'h5000_0100, 16'h0, 26'h010_0040, 32'h3, 32'h0);
    chk("R6 direct", next_pc, 32'h5040_0100);
    chk("R6 redirect", {31'b0, redirect}, 32'd1);
    drive(4'd7, 32'h4FFF_FFFC, 16'h0, 26'h0, 32'h0, 32'h0);
    chk("R6 region after increment", next_pc, 32'h5000_0000);
  endtask

  task automatic t_jump_reg;
    drive(4'd8, 32'h100, 16'h0, 26'h0, 32'h1234_5678, 32'h0);
    chk("R7 reg target", next_pc, 32'h1234_5678);
    chk("R7 redirect", {31'b0, redirect}, 32'd1);
    chk("R8 aligned", {31'b0, misaligned}, 32'd0);
    drive(4'd8, 32'h100, 16'h0, 26'h0, 32'h1234_5679, 32'h0);
    chk("R8 misaligned", {31'b0, misaligned}, 32'd1);
    drive(4'd12, 32'h100, 16'h0, 26'h0, 32'h0000_0202, 32'h0);
    chk("R8 misaligned link", {31'b0, misaligned}, 32'd1);
    drive(4'd7, 32'h100, 16'h0, 26'h1, 32'h3, 32'h0);
    chk("R8 direct no flag", {31'b0, misaligned}, 32'd0);
    drive(4'd1, 32'h100, 16'h1, 26'h0, 32'h3, 32'h3);
    chk("R8 branch no flag", {31'b0, misaligned}, 32'd0);
  endtask

  task automatic t_link;
    drive(4'd9, 32'h0040_0010, 16'h4, 26'h0, 32'h1, 32'h0);
    chk("R9 bltzal untaken link_en", {31'b0, link_en}, 32'd1);
    chk("R9 bltzal untaken addr", link_addr, 32'h0040_0014);
    chk("R9 bltzal untaken pc", next_pc, 32'h0040_0014);
    drive(4'd10, 32'h0040_0010, 16'h4, 26'h0, 32'h1, 32'h0);
    chk("R9 bgezal taken pc", next_pc, 32'h0040_0024);
    chk("R9 bgezal link", {31'b0, link_en}, 32'd1);
    drive(4'd11, 32'h0040_0010, 16'h0, 26'h000_0040, 32'h0, 32'h0);
    chk("R9 jal pc", next_pc, 32'h0000_0100);
    chk("R9 jal link", link_addr, 32'h0040_0014);
    drive(4'd12, 32'h0040_0010, 16'h0, 26'h0, 32'h0080_0000, 32'h0);
    chk("R9 jalr pc", next_pc, 32'h0080_0000);
    chk("R9 jalr link_en", {31'b0, link_en}, 32'd1);
    drive(4'd3, 32'h0040_0010, 16'h4, 26'h0, 32'hFFFF_FFFF, 32'h0);
    chk("R9 plain ltz no link", {31'b0, link_en}, 32'd0);
  endtask

  task automatic t_unused_codes;
    for (int c = 13; c <= 15; c++) begin
      drive(4'(c), 32'h0000_2000, 16'h0010, 26'h3FF_FFFF, 32'h0000_0001, 32'h0000_0001);
      chk("R10 unused pc", next_pc, 32'h0000_2004);
      chk("R10 unused flags", {29'b0, redirect, link_en, misaligned}, 32'd0);
    end
  endtask

  task automatic t_wrap;
    drive(4'd0, 32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 32'h0);
    chk("R11 wrap seq", next_pc, 32'h0000_0000);
    drive(4'd1, 32'hFFFF_FFF8, 16'h0002, 26'h0, 32'h0, 32'h0);
    chk("R11 wrap branch", next_pc, 32'h0000_0004);
  endtask

  initial begin
    ctl_code = 4'd0; pc = '0; disp16 = '0; jump_field = '0; opnd_a = '0; opnd_b = '0;
    repeat (2) @(posedge clk);
    t_sequential();
    t_equality();
    t_zero_cmp();
    t_br_target();
    t_jump_region();
    t_jump_reg();
    t_link();
    t_unused_codes();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule